// File: doc/BRIEF.md
# Register-Mapped General-Purpose I/O Controller

This block gives software control of a parameterised set of general-purpose I/O lines (up to 256) through a small synchronous register bus. Each request carries a 10-bit address, 16-bit write data and a write or read strobe. It is answered one cycle later by an acknowledge, and for reads by the returned word. Every line owns a 16-bit configuration and status word. That word holds the driven level, the output and input path enables, the pull-up, pull-down and open-drain enables, and a 4-bit bank number for a pin multiplexer further downstream. It also shows the live pad level.

Two further windows give single-bit access to the driven level and to the sampled pad level. Software can toggle a line or poll a pad through them without a read-modify-write of the full word. Pad levels enter through a two-flop synchroniser. The pad-facing outputs are decoded from the stored configuration, and the open-drain mode turns the driven level into a drive enable.

Top module: `gpio_bus_ctrl`

## Requirements
- R1: Address bits [9:8] pick the window (0 = configuration word, 1 = driven level, 2 = pad level, 3 = unused) and bits [7:0] pick the line; no two distinct addresses reach the same state.
- R2: A window-0 write stores only the writable bits (mask 0x0F77: bit 0 level, bit 1 output enable, bit 2 input enable, bit 4 open-drain, bit 5 pull-up, bit 6 pull-down, bits 11:8 bank). A window-0 read returns them in the same positions. Bits 15:13, 7 and 3 always read as zero.
- R3: Bit 12 of a window-0 read is the synchronised pad level of that line; writes to bit 12 are ignored.
- R4: A window-1 write changes only the driven level of the line, taking it from wdata bit 0. A window-1 read returns that level in bit 0, with all other bits zero.
- R5: A window-2 read returns the synchronised pad level in bit 0, with all other bits zero; window-2 writes change nothing.
- R6: Any access to window 3, or to a line index at or above NUM_LINES, reads as zero, is acknowledged, and changes nothing.
- R7: Every cycle with a write or read strobe is followed in the next cycle by ack high; ack is low in any other cycle. rdata is zero whenever ack is low and after a write. If both strobes are high, the write is performed and the read is dropped.
- R8: Reset clears every configuration field, so every line is an undriven input with pulls off, open-drain off and bank 0.
- R9: A pad level change made just before clock edge k is not seen by reads sampled at edges k and k+1, and is seen by reads sampled at edge k+2 and later.
- R10: With open-drain off, pad_oe follows the output enable and pad_out follows the driven level.
- R11: With open-drain on, pad_out is 0 and pad_oe is the inverse of the driven level, whatever the output enable.
- R12: pad_ien, pad_pu, pad_pd, pad_od and each line's 4-bit bank_sel slice follow the stored fields of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Window [9:8] and line index [7:0] |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Acknowledge, one cycle after a strobe |
| pad_in | input | NUM_LINES | Raw pad levels |
| pad_out | output | NUM_LINES | Level presented to each pad driver |
| pad_oe | output | NUM_LINES | Effective drive enable per pad |
| pad_ien | output | NUM_LINES | Input path enable per pad |
| pad_pu | output | NUM_LINES | Pull-up enable per pad |
| pad_pd | output | NUM_LINES | Pull-down enable per pad |
| pad_od | output | NUM_LINES | Open-drain mode per pad |
| bank_sel | output | 4*NUM_LINES | Bank number per line, line i in bits [4i+3:4i] |

## Verification
A four-line instance receives sixty-four scrambled 16-bit words on each line's configuration window. Each word sets reserved bits, bit 12 and every mode combination, so the readback and the decoded pad outputs separate the writable mask and the open-drain and push-pull drive rules. The unchanged outputs of the other lines expose any mis-decoded line index. Every 4-bit pad pattern is applied in turn, and the first line is polled at the first three edges after each change to pin the synchroniser latency. Writes and reads to the pad window, the unused window and indices past the line count then show that these accesses leave the outputs intact and return zero.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 16;
    localparam int IDX_W   = 8;
    localparam int BANK_W  = 4;
    localparam int MAX_LINES = 1 << IDX_W;

    // bit positions inside the per-line configuration word
    localparam int B_LVL  = 0;
    localparam int B_OE   = 1;
    localparam int B_IEN  = 2;
    localparam int B_OD   = 4;
    localparam int B_PU   = 5;
    localparam int B_PD   = 6;
    localparam int B_BANK = 8;
    localparam int B_PIN  = 12;

    typedef enum logic [1:0] {
        WIN_CFG  = 2'd0,
        WIN_LVL  = 2'd1,
        WIN_PIN  = 2'd2,
        WIN_NONE = 2'd3
    } win_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              pd;
        logic              pu;
        logic              od;
        logic              ien;
        logic              oe;
        logic              lvl;
    } line_cfg_t;

    function automatic logic [DATA_W-1:0] cfg_to_word(line_cfg_t c, logic pin);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_LVL]                   = c.lvl;
        w[B_OE]                    = c.oe;
        w[B_IEN]                   = c.ien;
        w[B_OD]                    = c.od;
        w[B_PU]                    = c.pu;
        w[B_PD]                    = c.pd;
        w[B_BANK +: BANK_W]        = c.bank;
        w[B_PIN]                   = pin;
        return w;
    endfunction

    function automatic line_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
        line_cfg_t c;
        c.lvl  = w[B_LVL];
        c.oe   = w[B_OE];
        c.ien  = w[B_IEN];
        c.od   = w[B_OD];
        c.pu   = w[B_PU];
        c.pd   = w[B_PD];
        c.bank = w[B_BANK +: BANK_W];
        return c;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stage2;
        logic [WIDTH-1:0] stage1;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = raw_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.stage2;

endmodule

// File: rtl/gpio_line_cfg.sv
module gpio_line_cfg
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  win_e                         wr_win_i,
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    output line_cfg_t [NUM_LINES-1:0]    cfg_o
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        line_cfg_t cfg_d, cfg_q;
        logic      hit;

        assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

        always_comb begin
            cfg_d = cfg_q;
            if (hit) begin
                unique case (wr_win_i)
                    WIN_CFG: cfg_d     = word_to_cfg(wr_data_i);
                    WIN_LVL: cfg_d.lvl = wr_data_i[B_LVL];
                    default: cfg_d     = cfg_q;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q <= '0;
            end else begin
                cfg_q <= cfg_d;
            end
        end

        assign cfg_o[g] = cfg_q;
    end

endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic                       we_i,
    input  logic                       re_i,
    input  line_cfg_t [NUM_LINES-1:0]  cfg_i,
    input  logic [NUM_LINES-1:0]       pin_i,
    output logic                       wr_en_o,
    output win_e                       wr_win_o,
    output logic [IDX_W-1:0]           wr_idx_o,
    output logic [DATA_W-1:0]          rdata_o,
    output logic                       ack_o
);

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    resp_t             resp_d, resp_q;
    logic [IDX_W-1:0]  idx;
    win_e              win;
    logic              in_range;
    line_cfg_t         sel_cfg;
    logic              sel_pin;
    logic [DATA_W-1:0] rd_word;

    assign idx      = addr_i[IDX_W-1:0];
    assign win      = win_e'(addr_i[ADDR_W-1:IDX_W]);
    assign in_range = (int'(idx) < NUM_LINES);

    // line selection without out-of-range array indexing
    always_comb begin
        sel_cfg = '0;
        sel_pin = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_cfg = cfg_i[i];
                sel_pin = pin_i[i];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (in_range) begin
            unique case (win)
                WIN_CFG: rd_word = cfg_to_word(sel_cfg, sel_pin);
                WIN_LVL: rd_word[0] = sel_cfg.lvl;
                WIN_PIN: rd_word[0] = sel_pin;
                default: rd_word = '0;
            endcase
        end
    end

    assign wr_en_o  = we_i && in_range && ((win == WIN_CFG) || (win == WIN_LVL));
    assign wr_win_o = win;
    assign wr_idx_o = idx;

    always_comb begin
        resp_d       = resp_q;
        resp_d.ack   = we_i || re_i;
        resp_d.rdata = (re_i && !we_i) ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rdata_o = resp_q.rdata;
    assign ack_o   = resp_q.ack;

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  line_cfg_t [NUM_LINES-1:0]     cfg_i,
    output logic [NUM_LINES-1:0]          pad_out_o,
    output logic [NUM_LINES-1:0]          pad_oe_o,
    output logic [NUM_LINES-1:0]          pad_ien_o,
    output logic [NUM_LINES-1:0]          pad_pu_o,
    output logic [NUM_LINES-1:0]          pad_pd_o,
    output logic [NUM_LINES-1:0]          pad_od_o,
    output logic [BANK_W*NUM_LINES-1:0]   bank_o
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_pad
        always_comb begin
            if (cfg_i[g].od) begin
                // open drain: pull low for a 0, release for a 1
                pad_out_o[g] = 1'b0;
                pad_oe_o[g]  = ~cfg_i[g].lvl;
            end else begin
                pad_out_o[g] = cfg_i[g].lvl;
                pad_oe_o[g]  = cfg_i[g].oe;
            end
        end
        assign pad_ien_o[g]                 = cfg_i[g].ien;
        assign pad_pu_o[g]                  = cfg_i[g].pu;
        assign pad_pd_o[g]                  = cfg_i[g].pd;
        assign pad_od_o[g]                  = cfg_i[g].od;
        assign bank_o[g*BANK_W +: BANK_W]   = cfg_i[g].bank;
    end

endmodule

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [9:0]                    bus_addr,
    input  logic [15:0]                   bus_wdata,
    input  logic                          bus_we,
    input  logic                          bus_re,
    output logic [15:0]                   bus_rdata,
    output logic                          bus_ack,
    input  logic [NUM_LINES-1:0]          pad_in,
    output logic [NUM_LINES-1:0]          pad_out,
    output logic [NUM_LINES-1:0]          pad_oe,
    output logic [NUM_LINES-1:0]          pad_ien,
    output logic [NUM_LINES-1:0]          pad_pu,
    output logic [NUM_LINES-1:0]          pad_pd,
    output logic [NUM_LINES-1:0]          pad_od,
    output logic [4*NUM_LINES-1:0]        bank_sel
);

    line_cfg_t [NUM_LINES-1:0] cfg;
    logic [NUM_LINES-1:0]      pin_sync;
    logic                      wr_en;
    win_e                      wr_win;
    logic [IDX_W-1:0]          wr_idx;

    gpio_in_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .sync_o (pin_sync)
    );

    gpio_bus_port #(.NUM_LINES(NUM_LINES)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .we_i     (bus_we),
        .re_i     (bus_re),
        .cfg_i    (cfg),
        .pin_i    (pin_sync),
        .wr_en_o  (wr_en),
        .wr_win_o (wr_win),
        .wr_idx_o (wr_idx),
        .rdata_o  (bus_rdata),
        .ack_o    (bus_ack)
    );

    gpio_line_cfg #(.NUM_LINES(NUM_LINES)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_win_i  (wr_win),
        .wr_idx_i  (wr_idx),
        .wr_data_i (bus_wdata),
        .cfg_o     (cfg)
    );

    gpio_pad_drive #(.NUM_LINES(NUM_LINES)) u_pad (
        .cfg_i     (cfg),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe),
        .pad_ien_o (pad_ien),
        .pad_pu_o  (pad_pu),
        .pad_pd_o  (pad_pd),
        .pad_od_o  (pad_od),
        .bank_o    (bank_sel)
    );

endmodule

// File: rtl/gpio_bus_ctrl_chk.sv
module gpio_bus_ctrl_chk #(
    parameter int NUM_LINES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [9:0]             bus_addr,
    input logic                   bus_we,
    input logic                   bus_re,
    input logic [15:0]            bus_rdata,
    input logic                   bus_ack,
    input logic [NUM_LINES-1:0]   pad_out,
    input logic [NUM_LINES-1:0]   pad_oe,
    input logic [NUM_LINES-1:0]   pad_ien,
    input logic [NUM_LINES-1:0]   pad_pu,
    input logic [NUM_LINES-1:0]   pad_pd,
    input logic [NUM_LINES-1:0]   pad_od,
    input logic [4*NUM_LINES-1:0] bank_sel
);

    logic [10*NUM_LINES-1:0] pad_state;
    logic                    bad_target;

    assign pad_state  = {pad_out, pad_oe, pad_ien, pad_pu, pad_pd, pad_od, bank_sel};
    assign bad_target = (bus_addr[9:8] == 2'b11) || (int'(bus_addr[7:0]) >= NUM_LINES);

    assert_ack_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we || bus_re) |=> bus_ack);

    assert_no_spurious_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we || bus_re) |=> !bus_ack);

    assert_rdata_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> (bus_rdata == '0));

    assert_od_never_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & pad_od) == '0));

    assert_bad_target_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bad_target) |=> $stable(pad_state));

    assert_pin_window_write_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[9:8] == 2'b10) |=> $stable(pad_state));

    assert_idle_inert_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_state));

endmodule

bind gpio_bus_ctrl gpio_bus_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_ien   (pad_ien),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .pad_od    (pad_od),
    .bank_sel  (bank_sel)
);

// File: tb/tb_gpio_bus_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bus_ctrl;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [9:0]     bus_addr;
    logic [15:0]    bus_wdata;
    logic           bus_we;
    logic           bus_re;
    logic [15:0]    bus_rdata;
    logic           bus_ack;
    logic [N-1:0]   pad_in;
    logic [N-1:0]   pad_out, pad_oe, pad_ien, pad_pu, pad_pd, pad_od;
    logic [4*N-1:0] bank_sel;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mdl [N];

    always #2 clk = ~clk;

    gpio_bus_ctrl #(.NUM_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ien(pad_ien),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_od(pad_od), .bank_sel(bank_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negative edge; returns at the next one
    task automatic bus_write(input logic [9:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R7 write ack", {31'b0, bus_ack}, 32'd1);
        chk("R7 write rdata", {16'b0, bus_rdata}, 32'd0);
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [15:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        chk("R7 read ack", {31'b0, bus_ack}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic check_pads(input string req);
        logic [N-1:0]   e_out, e_oe, e_ien, e_pu, e_pd, e_od;
        logic [4*N-1:0] e_bank;
        for (int i = 0; i < N; i++) begin
            e_od[i]        = mdl[i][4];
            e_out[i]       = mdl[i][4] ? 1'b0 : mdl[i][0];
            e_oe[i]        = mdl[i][4] ? ~mdl[i][0] : mdl[i][1];
            e_ien[i]       = mdl[i][2];
            e_pu[i]        = mdl[i][5];
            e_pd[i]        = mdl[i][6];
            e_bank[4*i +: 4] = mdl[i][11:8];
        end
        chk({req, " R10/R11 pad_out"}, 32'(pad_out), 32'(e_out));
        chk({req, " R10/R11 pad_oe"}, 32'(pad_oe), 32'(e_oe));
        chk({req, " R12 pad_ien"}, 32'(pad_ien), 32'(e_ien));
        chk({req, " R12 pad_pu"}, 32'(pad_pu), 32'(e_pu));
        chk({req, " R12 pad_pd"}, 32'(pad_pd), 32'(e_pd));
        chk({req, " R12 pad_od"}, 32'(pad_od), 32'(e_od));
        chk({req, " R12 bank_sel"}, 32'(bank_sel), 32'(e_bank));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] w;
        logic [N-1:0] prev;
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
        pad_in = '0;
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        check_pads("R8 reset");
        for (int i = 0; i < N; i++) begin
            bus_read({2'b00, 8'(i)}, rd);
            chk("R8 reset cfg word", 32'(rd), 32'd0);
        end
        @(negedge clk);
        chk("R7 idle ack low", {31'b0, bus_ack}, 32'd0);

        // R1 R2 R3 R10 R11 R12: scrambled configuration words on every line
        for (int ln = 0; ln < N; ln++) begin
            for (int v = 0; v < 64; v++) begin
                w = 16'(v * 16'h1357) ^ 16'hA5A5 ^ 16'(ln << 3);
                bus_write({2'b00, 8'(ln)}, w);
                mdl[ln] = w & 16'h0F77;
                check_pads("R2 sweep");
                bus_read({2'b00, 8'(ln)}, rd);
                chk("R2 cfg readback", 32'(rd), 32'(mdl[ln]));
            end
        end

        // R11: open-drain overrides output enable
        bus_write(10'h000, 16'h0012); mdl[0] = 16'h0012;
        chk("R11 od low drives", {30'b0, pad_oe[0], pad_out[0]}, 32'b10);
        bus_write(10'h000, 16'h0011); mdl[0] = 16'h0011;
        chk("R11 od high releases", {30'b0, pad_oe[0], pad_out[0]}, 32'b00);
        // R10: push-pull
        bus_write(10'h000, 16'h0003); mdl[0] = 16'h0003;
        chk("R10 push-pull", {30'b0, pad_oe[0], pad_out[0]}, 32'b11);

        // R4: level window
        for (int ln = 0; ln < N; ln++) begin
            for (int b = 0; b < 2; b++) begin
                bus_write({2'b01, 8'(ln)}, 16'hFFFE | 16'(b));
                mdl[ln][0] = b[0];
                check_pads("R4 level write");
                bus_read({2'b01, 8'(ln)}, rd);
                chk("R4 level read", 32'(rd), 32'(b));
                bus_read({2'b00, 8'(ln)}, rd);
                chk("R4 cfg after level write", 32'(rd), 32'(mdl[ln]));
            end
        end

        // R3 R5 R9: every pad pattern
        prev = '0;
        for (int p = 0; p < 16; p++) begin
            pad_in = N'(p);
            bus_read(10'h200, rd);
            chk("R9 first edge old", 32'(rd), 32'(prev[0]));
            bus_read(10'h200, rd);
            chk("R9 second edge old", 32'(rd), 32'(prev[0]));
            bus_read(10'h200, rd);
            chk("R9 third edge new", 32'(rd), 32'(p & 1));
            for (int ln = 0; ln < N; ln++) begin
                bus_read({2'b10, 8'(ln)}, rd);
                chk("R5 pin window", 32'(rd), 32'((p >> ln) & 1));
                bus_read({2'b00, 8'(ln)}, rd);
                chk("R3 cfg pin bit", 32'(rd), 32'(mdl[ln] | 16'(((p >> ln) & 1) << 12)));
            end
            prev = N'(p);
        end
        pad_in = '0;
        repeat (3) @(negedge clk);

        // R5: writes to the pin window do nothing
        for (int ln = 0; ln < N; ln++) begin
            bus_write({2'b10, 8'(ln)}, 16'hFFFF);
            check_pads("R5 pin write ignored");
        end

        // R6 R1: unused window and out-of-range lines
        bus_write(10'h300, 16'hFFFF);
        check_pads("R6 window3 write");
        bus_read(10'h301, rd);
        chk("R6 window3 read", 32'(rd), 32'd0);
        bus_write({2'b00, 8'(N)}, 16'hFFFF);
        check_pads("R6 index N write");
        bus_write(10'h0FF, 16'hFFFF);
        check_pads("R6 index 255 write");
        bus_write({2'b01, 8'hC8}, 16'hFFFF);
        check_pads("R1 no alias level write");
        bus_read({2'b00, 8'(N)}, rd);
        chk("R6 out-of-range read", 32'(rd), 32'd0);
        bus_read({2'b10, 8'hFF}, rd);
        chk("R6 out-of-range pin read", 32'(rd), 32'd0);

        // R7: simultaneous strobes perform the write, return zero
        bus_addr = 10'h001; bus_wdata = 16'h0F77; bus_we = 1'b1; bus_re = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0; mdl[1] = 16'h0F77;
        chk("R7 dual strobe ack", {31'b0, bus_ack}, 32'd1);
        chk("R7 dual strobe rdata", 32'(bus_rdata), 32'd0);
        check_pads("R7 dual strobe write");
        @(negedge clk);
        chk("R7 ack drops", {31'b0, bus_ack}, 32'd0);

        // R8: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) mdl[i] = '0;
        check_pads("R8 second reset");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule